// File: doc/BRIEF.md
# Cascaded Multi-Modulus Pulse-Swallow Divider

This block divides a fast clock by a programmable integer between 64 and 127. A front stage takes the fast clock and normally divides it by four. It is built from two cascaded halvers whose four staggered phases feed a 4-to-1 selector. Moving the selector forward by one to three phases stretches one front period by that many input cycles. The front stage is followed by a chain of four divide-by-2/3 cells. Each cell normally halves the rate of its input ticks. When its control bit is set, the cell absorbs one extra input tick per output period. The cell at chain position k therefore adds 2^k front ticks, which is 4·2^k fast-clock cycles.

The six-bit control word sets the modulus to 64 plus the word's value. Bits [1:0] give the front-stage stretch of 0 to 3 cycles, and bits [5:2] drive the cells, with the lowest of them nearest the front. The whole block runs on the fast clock as single-clock logic. The word is captured only at the end of an output period, and the block reports that moment with a one-cycle boundary strobe. The divided clock rises in the same cycle as the strobe.

Top module: `pulse_swallow_div`

## Requirements
- R1: While reset is held, and in the first cycle after it, the boundary strobe is low and the divided clock is high.
- R2: The interval between consecutive boundary strobes is 64 + W fast-clock cycles. W is the control word latched at the first of those two strobes, so the achievable moduli cover every integer from 64 to 127.
- R3: Control bits [1:0] alone add 0, 1, 2 or 3 cycles to the period, so W = 0..3 gives periods of 64..67. Inside the block, front-stage ticks are always 4 to 7 cycles apart.
- R4: Control bit k, for k = 2..5, adds exactly 2^k cycles when set by itself. The cell contributions are binary weighted.
- R5: The control word is sampled only in the cycle that ends an output period. Values applied and then withdrawn partway through a period have no effect on that period or on any later one.
- R6: The boundary strobe is high for exactly one cycle per output period.
- R7: The divided clock is low in the cycle before each strobe and high during the strobe, so its rising edge marks the period boundary.
- R8: A different control word in every consecutive period, including jumps between the extremes 0 and 63, is honoured period by period with no corrupted interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ctrl_i | input | 6 | Modulus control word W; period = 64 + W |
| div_clk_o | output | 1 | Divided clock, rising at each period boundary |
| bound_o | output | 1 | One-cycle strobe marking the end of each output period |

## Verification
The bench sweeps all 64 control words in ascending order, one per period. This shows that every modulus from 64 to 127 is reachable and that each period is measured correctly. It also applies each control bit by itself and a pattern of adjacent-bit pairs. These separate the front-stage phase stretch from the cell absorption and expose any weighting or bit-order error in the chain. Words alternating between 0 and 63, and a descending sweep, test back-to-back changes at the extremes. A run of words that are briefly replaced by other values in mid-period shows that the word is captured only at the boundary.

// File: rtl/psd_pkg.sv
package psd_pkg;

    localparam int FRONT_W      = 2;
    localparam int FRONT_PHASES = 1 << FRONT_W;

    typedef struct packed {
        logic [FRONT_W-1:0] cnt;   // two cascaded halvers, as one count
        logic [FRONT_W-1:0] sel;   // selected phase of the 4-to-1 mux
        logic               skip;  // ignore the first match after a shift
    } front_st_t;

    typedef struct packed {
        logic ph;    // which half of the 2/3 cycle the cell is in
        logic ext;   // extra tick already absorbed this output period
    } cell_st_t;

endpackage

// File: rtl/psd_front.sv
module psd_front
    import psd_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [FRONT_W-1:0] stretch_i,
    input  logic               load_i,
    output logic               tick_o
);

    front_st_t st_q, st_d;

    logic [FRONT_W-1:0] phase_pos [FRONT_PHASES];
    logic [FRONT_W-1:0] sel_pos;
    logic               match;

    // Four staggered phases of the divide-by-4; each lags the previous by one cycle
    for (genvar k = 0; k < FRONT_PHASES; k++) begin : g_phase
        assign phase_pos[k] = st_q.cnt - FRONT_W'(k);
    end

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
        sel_pos  = phase_pos[st_q.sel];
        match    = (sel_pos == '0);
        tick_o   = match && !st_q.skip;
        if (match && st_q.skip) begin
            st_d.skip = 1'b0;
        end
        if (tick_o && load_i) begin
            // shifting to a later phase stretches the next front period
            st_d.sel  = st_q.sel + stretch_i;
            st_d.skip = (stretch_i != '0);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/psd_cell.sv
module psd_cell
    import psd_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,   // input tick from the stage below
    input  logic win_i,    // every cell above sits in its second half
    input  logic ctl_i,    // absorb one extra tick per output period
    input  logic clr_i,    // output period ends this cycle
    output logic tick_o,
    output logic ph_o
);

    cell_st_t st_q, st_d;
    logic     absorb;

    always_comb begin
        st_d   = st_q;
        absorb = tick_i && st_q.ph && win_i && ctl_i && !st_q.ext;
        tick_o = tick_i && st_q.ph && !absorb;
        if (tick_i && !absorb) begin
            st_d.ph = ~st_q.ph;
        end
        if (absorb) begin
            st_d.ext = 1'b1;
        end
        if (clr_i) begin
            st_d.ext = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ph_o = st_q.ph;

endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
    import psd_pkg::*;
#(
    parameter int NCELL  = 4,
    localparam int CTRL_W = FRONT_W + NCELL
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic              div_clk_o,
    output logic              bound_o
);

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic              strobe;
    } top_st_t;

    top_st_t          st_q, st_d;
    logic [NCELL:0]   tk;
    logic [NCELL:0]   win;
    logic [NCELL-1:0] ph;
    logic             f_tick;
    logic             out_tick;

    psd_front u_front (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .stretch_i (ctrl_i[FRONT_W-1:0]),
        .load_i    (out_tick),
        .tick_o    (f_tick)
    );

    assign tk[0]      = f_tick;
    assign win[NCELL] = 1'b1;

    for (genvar k = 0; k < NCELL; k++) begin : g_cell
        assign win[k] = win[k+1] & ph[k];
        psd_cell u_cell (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .tick_i (tk[k]),
            .win_i  (win[k+1]),
            .ctl_i  (st_q.ctrl[FRONT_W+k]),
            .clr_i  (out_tick),
            .tick_o (tk[k+1]),
            .ph_o   (ph[k])
        );
    end

    assign out_tick = tk[NCELL];

    always_comb begin
        st_d        = st_q;
        st_d.strobe = out_tick;
        if (out_tick) begin
            st_d.ctrl = ctrl_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bound_o   = st_q.strobe;
    assign div_clk_o = ~ph[NCELL-1];

endmodule

// File: rtl/psd_checker.sv
module psd_checker #(
    parameter int CTRL_W = 6
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic [CTRL_W-1:0] ctrl_i,
    input logic              div_clk_o,
    input logic              bound_o,
    input logic              f_tick
);

    localparam int CW = CTRL_W + 2;
    localparam logic [CW-1:0] BASE = CW'(1 << CTRL_W);

    logic [CW-1:0]     per_cnt, exp_mod;
    logic              exp_ok;
    logic [CTRL_W-1:0] ctrl_prev;
    logic [3:0]        fr_cnt;
    logic              fr_ok;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            per_cnt   <= '0;
            exp_mod   <= '0;
            exp_ok    <= 1'b0;
            ctrl_prev <= '0;
            fr_cnt    <= '0;
            fr_ok     <= 1'b0;
        end else begin
            ctrl_prev <= ctrl_i;
            if (bound_o) begin
                per_cnt <= CW'(1);
                exp_mod <= BASE + CW'(ctrl_prev);
                exp_ok  <= 1'b1;
            end else if (per_cnt != '1) begin
                per_cnt <= per_cnt + 1'b1;
            end
            if (f_tick) begin
                fr_cnt <= 4'd1;
                fr_ok  <= 1'b1;
            end else if (fr_cnt != 4'hF) begin
                fr_cnt <= fr_cnt + 1'b1;
            end
        end
    end

    AST_PERIOD_MATCH: assert property (@(posedge clk_i) disable iff (rst_i)
        (bound_o && exp_ok) |-> (per_cnt == exp_mod)); // R2

    AST_FRONT_SPAN: assert property (@(posedge clk_i) disable iff (rst_i)
        (f_tick && fr_ok) |-> (fr_cnt >= 4'd4 && fr_cnt <= 4'd7)); // R3

    AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        bound_o |=> !bound_o); // R6

    AST_RISE_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(div_clk_o) |-> bound_o); // R7

endmodule

bind pulse_swallow_div psd_checker #(.CTRL_W(CTRL_W)) u_psd_checker (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .ctrl_i    (ctrl_i),
    .div_clk_o (div_clk_o),
    .bound_o   (bound_o),
    .f_tick    (f_tick)
);

// File: tb/pulse_swallow_div_bench.sv
`timescale 1ns/1ps
module pulse_swallow_div_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] ctrl;
    logic       div_clk;
    logic       bound;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_q[$];
    string tag_q[$];
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pulse_swallow_div u_pulse_swallow_div (
        .clk_i     (clk),
        .rst_i     (rst),
        .ctrl_i    (ctrl),
        .div_clk_o (div_clk),
        .bound_o   (bound)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // driver: new word one cycle after a boundary, expected modulus queued
    task automatic apply(input int v, input string tag);
        @(negedge clk);
        while (!bound) @(negedge clk);
        @(negedge clk);
        ctrl = 6'(v);
        exp_q.push_back(64 + v);
        tag_q.push_back(tag);
    endtask

    // R5: noise value present mid-period, final value restored before the boundary
    task automatic apply_noisy(input int v, input int noise);
        @(negedge clk);
        while (!bound) @(negedge clk);
        @(negedge clk);
        ctrl = 6'(v);
        exp_q.push_back(64 + v);
        tag_q.push_back("R5");
        repeat (10) @(negedge clk);
        ctrl = 6'(noise);
        repeat (20) @(negedge clk);
        ctrl = 6'(v);
    endtask

    // monitor: measures boundary spacing and strobe/clock shape
    initial begin : monitor
        int    cyc = 0;
        int    last = 0;
        bit    exp_ok = 1'b0;
        int    exp_v = 0;
        string exp_tag = "";
        logic  prev_bound = 1'b0;
        logic  prev_clk = 1'b1;
        forever begin
            @(negedge clk);
            cyc++;
            if (!rst) begin
                if (prev_bound) check(!bound, "R6", int'(bound), 0);
                if (bound) begin
                    check(div_clk && !prev_clk, "R7", {30'd0, prev_clk, div_clk}, 1);
                    if (exp_ok) check(cyc - last == exp_v, exp_tag, cyc - last, exp_v);
                    if (exp_q.size() > 0) begin
                        exp_v   = exp_q.pop_front();
                        exp_tag = tag_q.pop_front();
                        exp_ok  = 1'b1;
                    end else begin
                        exp_ok = 1'b0;
                    end
                    last = cyc;
                end
            end
            prev_bound = bound;
            prev_clk   = div_clk;
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : driver
        rst  = 1'b1;
        ctrl = '0;
        repeat (4) @(negedge clk);
        check(!bound && div_clk, "R1", {30'd0, bound, div_clk}, 1);
        exp_q.push_back(64);
        tag_q.push_back("R2");
        rst = 1'b0;
        @(negedge clk);
        check(!bound && div_clk, "R1", {30'd0, bound, div_clk}, 1);

        for (int v = 0; v < 64; v++) apply(v, "R2");
        for (int v = 0; v < 4; v++) apply(v, "R3");
        for (int b = 2; b < 6; b++) apply(1 << b, "R4");
        for (int b = 0; b < 5; b++) apply(3 << b, "R4");
        for (int i = 0; i < 8; i++) apply((i % 2) ? 63 : 0, "R8");
        for (int v = 63; v >= 0; v -= 7) apply(v, "R8");
        apply_noisy(5, 63);
        apply_noisy(40, 0);
        apply_noisy(63, 17);
        apply(0, "R5");

        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        while (!bound) @(negedge clk);
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule